// File: doc/BRIEF.md
# Configurable SPI Bus Master

This block is a full-duplex SPI master. A host loads a parallel word and asks for a transfer by raising a write strobe. The block then drives the word out on the serial data line most significant bit first and reads the incoming line in the same SCLK periods. When the last bit is done it releases the select line, stores the received word and raises one interrupt that covers both directions. The clock polarity and phase are chosen per transfer from two host inputs, so any of the four SPI modes can be used without rebuilding the design.

A free-running step divider produces a tick at twice the SCLK rate. Each tick moves the control logic by one half SCLK period, so every SCLK period has one launch step and one sample step. The host control inputs (write strobe, interrupt acknowledge and clock enable) are asynchronous and each passes through a multi-flop synchroniser. Removing the clock enable freezes the divider and the sequencer. Word length, SCLK division and synchroniser depth are elaboration-time parameters.

Top module: `spi_host_engine`

## Requirements
- R1: After reset `spi_ss_n` is 1, `busy`, `irq` and `spi_mosi` are 0, `rx_word` is all zeros and `spi_sclk` sits at the level of `cpol`.
- R2: A rising edge on `wr_en`, seen after synchronisation while the block is idle and enabled, starts a transfer. In that cycle `busy` rises and `spi_ss_n` falls together, and they stay like that until the transfer ends.
- R3: Each transfer has exactly 2*WORD_W SCLK edges spaced 2*CLK_DIV system clocks apart. The first edge comes 2*CLK_DIV clocks after `spi_ss_n` falls, and `spi_ss_n` rises 2*CLK_DIV clocks after the last edge.
- R4: `spi_mosi` carries `tx_word` most significant bit first. A leading edge is an SCLK edge away from the `cpol` level. With `cpha`=0 each bit is valid at the leading edge and the first bit is valid from the fall of `spi_ss_n`. With `cpha`=1 a bit is launched on each leading edge and is valid at the following trailing edge.
- R5: `spi_miso` is sampled on the leading edge when `cpha`=0 and on the trailing edge when `cpha`=1. The bits are assembled most significant first, and the word appears on `rx_word` when `spi_ss_n` rises. It then holds until the next transfer completes.
- R6: While no transfer is running, `spi_sclk` follows `cpol`. A mode change made between transfers takes effect on the next transfer.
- R7: `irq` rises in the same cycle that `spi_ss_n` rises and `busy` falls.
- R8: `irq` stays high until a rising edge on `irq_ack` or the start of a new transfer clears it.
- R9: A rising edge on `wr_en` during a transfer is ignored. The word in flight is not changed and no extra transfer follows.
- R10: While `clk_en` is low, `spi_sclk`, `spi_ss_n` and `spi_mosi` hold their values, a transfer in progress pauses, and a write strobe is not accepted. When `clk_en` returns high, the paused transfer finishes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Activity enable, asynchronous, synchronised inside |
| wr_en | input | 1 | Transfer request, rising edge counts, asynchronous |
| irq_ack | input | 1 | Interrupt acknowledge, rising edge counts, asynchronous |
| cpol | input | 1 | SCLK idle level for the next transfer |
| cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| tx_word | input | WORD_W | Word to send, held stable until `busy` rises |
| rx_word | output | WORD_W | Last received word |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Transfer complete, level |
| spi_sclk | output | 1 | Serial clock |
| spi_ss_n | output | 1 | Active-low slave select |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |

## Verification
The bench runs a slave model that drives MISO on launch edges and records MOSI on sample edges. It checks every mode, because a design that swaps the launch and sample roles for one phase setting would shift both words by one bit. It measures the select setup time, the hold time and the edge spacing in clock cycles, which catches an extra or missing half-period at either end of the word. Directed cases send a second write during a transfer (a wrong design would reload the shifter or start a second frame), drop the enable in mid-word (a wrong design would lose or add edges), write while disabled, and check that a new write or an acknowledge clears a pending interrupt.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

   typedef enum logic {
      CTL_IDLE = 1'b0,
      CTL_RUN  = 1'b1
   } ctl_state_t;

   typedef struct packed {
      logic cpol;
      logic cpha;
   } spi_mode_t;

   // A sample step is the leading edge when cpha=0 and the trailing edge when cpha=1.
   function automatic logic is_sample_edge(input logic leading, input logic cpha);
      return leading ^ cpha;
   endfunction

endpackage

// File: rtl/spi_host_sync.sv
module spi_host_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_host_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_host_div.sv
module spi_host_div #(
   parameter int unsigned CLK_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic restart,
   output logic tick
);

   localparam int unsigned STEP = 2 * CLK_DIV;
   localparam int unsigned CW   = (STEP > 1) ? $clog2(STEP) : 1;

   if (CLK_DIV < 1) begin : g_bad_div
      $error("spi_host_div: CLK_DIV must be at least 1");
   end

   logic [CW-1:0] cnt;

   assign tick = en && (cnt == CW'(STEP - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (en)      cnt <= tick ? '0 : cnt + 1'b1;
   end

   // R10: with the enable removed the step counter does not move
   p_cnt_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !restart) |=> $stable(cnt));

endmodule

// File: rtl/spi_host_shift.sv
module spi_host_shift #(
   parameter int unsigned WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              cpha_in,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              launch,
   input  logic              sample,
   input  logic              finish,
   input  logic              miso,
   output logic              mosi,
   output logic [WORD_W-1:0] rx_word
);

   logic [WORD_W-1:0] tx_sh;
   logic [WORD_W-1:0] rx_sh;
   logic              mosi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh   <= '0;
         rx_sh   <= '0;
         mosi_q  <= 1'b0;
         rx_word <= '0;
      end else if (load) begin
         rx_sh <= '0;
         if (cpha_in) begin
            tx_sh  <= tx_word;
            mosi_q <= 1'b0;
         end else begin
            tx_sh  <= {tx_word[WORD_W-2:0], 1'b0};
            mosi_q <= tx_word[WORD_W-1];
         end
      end else if (finish) begin
         rx_word <= rx_sh;
         mosi_q  <= 1'b0;
      end else begin
         if (launch) begin
            mosi_q <= tx_sh[WORD_W-1];
            tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
         end
         if (sample) rx_sh <= {rx_sh[WORD_W-2:0], miso};
      end
   end

   assign mosi = mosi_q;

   // R4: the data line never moves on a sample step
   p_mosi_still_on_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sample |=> $stable(mosi_q));

   // R4/R5: a step is either a launch or a sample, never both
   p_single_role_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(launch && sample));

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
   import spi_host_pkg::*;
#(
   parameter int unsigned WORD_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic wr_rise,
   input  logic ack_rise,
   input  logic tick,
   input  logic cpol_in,
   input  logic cpha_in,
   output logic load,
   output logic launch,
   output logic sample,
   output logic finish,
   output logic busy,
   output logic irq,
   output logic ss_n,
   output logic sclk
);

   localparam int unsigned EDGES = 2 * WORD_W;
   localparam int unsigned EW    = $clog2(EDGES + 1);

   ctl_state_t    state;
   logic [EW-1:0] ecnt;
   spi_mode_t     mode_q;
   logic          sclk_q;
   logic          ss_q;
   logic          irq_q;

   logic step, at_end, edge_go, leading, smp_kind;

   assign load     = (state == CTL_IDLE) && en && wr_rise;
   assign step     = (state == CTL_RUN) && tick;
   assign at_end   = (ecnt == EW'(EDGES));
   assign edge_go  = step && !at_end;
   assign finish   = step && at_end;
   assign leading  = !ecnt[0];
   assign smp_kind = is_sample_edge(leading, mode_q.cpha);
   assign sample   = edge_go && smp_kind;
   assign launch   = edge_go && !smp_kind && (ecnt != EW'(EDGES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= CTL_IDLE;
         ecnt   <= '0;
         mode_q <= '0;
         sclk_q <= 1'b0;
         ss_q   <= 1'b1;
      end else if (load) begin
         state  <= CTL_RUN;
         ecnt   <= '0;
         mode_q <= '{cpol: cpol_in, cpha: cpha_in};
         sclk_q <= cpol_in;
         ss_q   <= 1'b0;
      end else if (edge_go) begin
         ecnt   <= ecnt + 1'b1;
         sclk_q <= ~sclk_q;
      end else if (finish) begin
         state <= CTL_IDLE;
         ss_q  <= 1'b1;
      end else if (state == CTL_IDLE) begin
         sclk_q <= cpol_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        irq_q <= 1'b0;
      else if (finish)   irq_q <= 1'b1;
      else if (load)     irq_q <= 1'b0;
      else if (ack_rise) irq_q <= 1'b0;
   end

   assign busy = (state == CTL_RUN);
   assign irq  = irq_q;
   assign ss_n = ss_q;
   assign sclk = sclk_q;

   // R2: select is low exactly while the sequencer runs
   p_select_follows_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy == !ss_q);

   // R3: the edge counter never runs past one word
   p_edge_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ecnt <= EW'(EDGES));

   // R6: SCLK is back at its idle level once the word ends
   p_idle_level_after_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> (sclk_q == mode_q.cpol));

   // R7: interrupt comes with the release of select
   p_irq_at_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ss_q) |-> (irq_q && !busy));

   // R8: a new transfer starts with the interrupt clear
   p_irq_clear_on_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !irq_q);

   // R9: the mode in use cannot change during a word
   p_mode_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !finish) |=> $stable(mode_q));

   // R10: a paused transfer keeps its serial lines still
   p_paused_lines_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !en) |=> ($stable(sclk_q) && $stable(ss_q) && $stable(ecnt)));

endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine #(
   parameter int unsigned WORD_W      = 8,
   parameter int unsigned CLK_DIV     = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en,
   input  logic              wr_en,
   input  logic              irq_ack,
   input  logic              cpol,
   input  logic              cpha,
   input  logic [WORD_W-1:0] tx_word,
   output logic [WORD_W-1:0] rx_word,
   output logic              busy,
   output logic              irq,
   output logic              spi_sclk,
   output logic              spi_ss_n,
   output logic              spi_mosi,
   input  logic              spi_miso
);

   localparam int unsigned NSYNC = 3;

   if (WORD_W < 2) begin : g_bad_word
      $error("spi_host_engine: WORD_W must be at least 2");
   end
   if (CLK_DIV < 1) begin : g_bad_div
      $error("spi_host_engine: CLK_DIV must be at least 1");
   end

   logic [NSYNC-1:0] ctl_raw, ctl_s;
   logic en_s, wr_s, ack_s, wr_q, ack_q, wr_rise, ack_rise;
   logic tick, load, launch, sample, finish;

   assign ctl_raw = {clk_en, wr_en, irq_ack};

   spi_host_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ctl_raw),
      .q     (ctl_s)
   );

   assign en_s  = ctl_s[2];
   assign wr_s  = ctl_s[1];
   assign ack_s = ctl_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= 1'b0;
         ack_q <= 1'b0;
      end else begin
         wr_q  <= wr_s;
         ack_q <= ack_s;
      end
   end

   assign wr_rise  = wr_s  && !wr_q;
   assign ack_rise = ack_s && !ack_q;

   spi_host_div #(.CLK_DIV(CLK_DIV)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en_s),
      .restart (load),
      .tick    (tick)
   );

   spi_host_ctrl #(.WORD_W(WORD_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_s),
      .wr_rise  (wr_rise),
      .ack_rise (ack_rise),
      .tick     (tick),
      .cpol_in  (cpol),
      .cpha_in  (cpha),
      .load     (load),
      .launch   (launch),
      .sample   (sample),
      .finish   (finish),
      .busy     (busy),
      .irq      (irq),
      .ss_n     (spi_ss_n),
      .sclk     (spi_sclk)
   );

   spi_host_shift #(.WORD_W(WORD_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .cpha_in (cpha),
      .tx_word (tx_word),
      .launch  (launch),
      .sample  (sample),
      .finish  (finish),
      .miso    (spi_miso),
      .mosi    (spi_mosi),
      .rx_word (rx_word)
   );

   // R9: a write strobe during a transfer never reloads the sequencer
   p_no_reload_when_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_rise) |-> !load);

endmodule

// File: tb/sim_spi_host_engine.sv
module sim_spi_host_engine;

   localparam int W = 8;
   localparam int D = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clk_en = 1'b0, wr_en = 1'b0, irq_ack = 1'b0, cpol = 1'b0, cpha = 1'b0;
   logic [W-1:0] tx_word = '0;
   logic [W-1:0] rx_word;
   logic busy, irq, spi_sclk, spi_ss_n, spi_mosi;
   logic spi_miso = 1'b0;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   spi_host_engine #(.WORD_W(W), .CLK_DIV(D), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wr_en(wr_en), .irq_ack(irq_ack),
      .cpol(cpol), .cpha(cpha), .tx_word(tx_word), .rx_word(rx_word),
      .busy(busy), .irq(irq), .spi_sclk(spi_sclk), .spi_ss_n(spi_ss_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   function automatic int half_period(input int div);
      return 2 * div;
   endfunction

   function automatic int edges_per_word(input int w);
      return 2 * w;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   // slave model and line monitor, sampled between clock edges
   int cyc = 0, fall_t = 0, first_t = 0, last_t = 0, rise_t = 0, edges = 0, gap_bad = 0;
   logic [W-1:0] mosi_cap = '0, slave_sh = '0, slave_word = '0;
   logic prev_sclk = 1'b0, prev_ss = 1'b1;
   bit cur_cpol = 0, cur_cpha = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (prev_ss && !spi_ss_n) begin
            fall_t = cyc; edges = 0; gap_bad = 0; mosi_cap = '0;
            slave_sh = slave_word;
            if (!cur_cpha) begin
               spi_miso = slave_sh[W-1];
               slave_sh = slave_sh << 1;
            end
         end
         if (!spi_ss_n && spi_sclk != prev_sclk) begin
            edges++;
            if (edges == 1) first_t = cyc;
            else if (cyc - last_t != half_period(D)) gap_bad++;
            last_t = cyc;
            if ((spi_sclk != cur_cpol) ^ cur_cpha) begin
               mosi_cap = {mosi_cap[W-2:0], spi_mosi};
            end else begin
               spi_miso = slave_sh[W-1];
               slave_sh = slave_sh << 1;
            end
         end
         if (!prev_ss && spi_ss_n) rise_t = cyc;
         prev_sclk = spi_sclk;
         prev_ss   = spi_ss_n;
      end
   end

   task automatic run_xfer(input logic [W-1:0] tx, input logic [W-1:0] sw,
                           input bit pol, input bit pha, input bit pause, input bit poke);
      bit seen;
      @(negedge clk);
      cpol = pol; cpha = pha; tx_word = tx; slave_word = sw;
      cur_cpol = pol; cur_cpha = pha;
      repeat (3) @(negedge clk);
      chk(spi_sclk == pol, "R6", "idle sclk level", spi_sclk, pol);
      wr_en = 1'b1;
      seen = 0;
      for (int i = 0; i < 12 && !seen; i++) begin
         @(negedge clk);
         if (busy) seen = 1;
      end
      chk(seen && !spi_ss_n, "R2", "start busy/ss", {busy, spi_ss_n}, 2'b10);
      chk(!irq, "R8", "irq cleared by new write", irq, 0);
      wr_en = 1'b0;
      if (poke) begin
         repeat (10) @(negedge clk);
         tx_word = ~tx;
         wr_en = 1'b1;
         repeat (6) @(negedge clk);
         wr_en = 1'b0;
      end
      if (pause) begin
         logic [2:0] snap;
         bit moved;
         repeat (25) @(negedge clk);
         clk_en = 1'b0;
         repeat (4) @(negedge clk);
         snap = {spi_sclk, spi_ss_n, spi_mosi};
         moved = 0;
         for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if ({spi_sclk, spi_ss_n, spi_mosi} != snap) moved = 1;
         end
         chk(!moved && busy, "R10", "lines frozen while disabled", {moved, busy}, 2'b01);
         clk_en = 1'b1;
      end
      seen = 0;
      for (int i = 0; i < 2000 && !seen; i++) begin
         @(negedge clk);
         if (!busy) seen = 1;
      end
      chk(seen, "R3", "transfer completes", seen, 1);
      chk(irq && spi_ss_n, "R7", "irq with select release", {irq, spi_ss_n}, 2'b11);
      @(negedge clk);
      chk(edges == edges_per_word(W), "R3", "edge count", edges, edges_per_word(W));
      chk(first_t - fall_t == half_period(D), "R3", "select setup", first_t - fall_t, half_period(D));
      chk(rise_t - last_t == half_period(D), "R3", "select hold", rise_t - last_t, half_period(D));
      if (!pause) chk(gap_bad == 0, "R3", "edge spacing", gap_bad, 0);
      chk(mosi_cap == tx, "R4", "mosi word", mosi_cap, tx);
      chk(rx_word == sw, "R5", "rx word", rx_word, sw);
      chk(spi_sclk == pol, "R6", "sclk idle after word", spi_sclk, pol);
      if (poke) begin
         repeat (10) @(negedge clk);
         chk(!busy && spi_ss_n, "R9", "no extra transfer", busy, 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd20240611);
      repeat (4) @(negedge clk);
      chk(spi_ss_n && !busy && !irq && !spi_mosi && rx_word == '0, "R1", "reset outputs",
          {spi_ss_n, busy, irq, spi_mosi, rx_word}, {4'b1000, 8'h00});
      rst_n = 1'b1;
      clk_en = 1'b1;
      repeat (3) @(negedge clk);
      chk(spi_ss_n && !busy && spi_sclk == 1'b0, "R1", "after reset release",
          {spi_ss_n, busy, spi_sclk}, 3'b100);

      // directed: all four modes, edge patterns
      run_xfer(8'hA5, 8'h3C, 0, 0, 0, 0);
      run_xfer(8'h81, 8'hFF, 0, 1, 0, 0);
      run_xfer(8'h00, 8'h81, 1, 0, 0, 0);
      run_xfer(8'hFF, 8'h00, 1, 1, 0, 0);

      // acknowledge clears the interrupt
      @(negedge clk);
      irq_ack = 1'b1;
      repeat (5) @(negedge clk);
      chk(!irq, "R8", "irq cleared by ack", irq, 0);
      irq_ack = 1'b0;
      repeat (3) @(negedge clk);
      chk(rx_word == 8'h00, "R5", "rx word held", rx_word, 8'h00);

      // write during a transfer
      run_xfer(8'h5A, 8'hC3, 0, 1, 0, 1);

      // write while disabled
      @(negedge clk);
      clk_en = 1'b0;
      repeat (5) @(negedge clk);
      wr_en = 1'b1;
      repeat (10) @(negedge clk);
      chk(!busy && spi_ss_n, "R10", "write ignored while disabled", busy, 0);
      wr_en = 1'b0;
      repeat (5) @(negedge clk);
      clk_en = 1'b1;
      repeat (10) @(negedge clk);
      chk(!busy, "R10", "no late start after enable", busy, 0);

      // paused transfer in two modes
      run_xfer(8'h96, 8'h69, 1, 0, 1, 0);
      run_xfer(8'h3E, 8'hD1, 0, 1, 1, 0);

      // random traffic with run-time mode changes
      for (int n = 0; n < 30; n++) begin
         logic [W-1:0] t, s;
         logic [1:0] m;
         t = W'($urandom);
         s = W'($urandom);
         m = 2'($urandom);
         run_xfer(t, s, m[1], m[0], 0, ($urandom % 5) == 0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule